// File: doc/BRIEF.md
# Packed 21-bit Character Slot Search

This unit looks for a character in a 64-bit word that holds three 21-bit character codes. On each cycle with `in_valid` high it takes the word and a 21-bit target code. One clock later it gives back, as a 64-bit signed value, the index of the first slot whose code equals the target. If no slot matches, it gives back -1.

String routines call it once per word. They use a target of zero to find the terminator. A negative result tells the loop to move on to the next word. A non-negative result ends the scan, and the string length is three per word already passed plus the returned index.

Slots are numbered from the least significant end. The top bit of the word belongs to no slot and never affects the result.

Top module: `ch21_search`

## Requirements
- R1: While `rst_n` is low, and on the first edge after it goes low, `out_valid` is 0 and `out_result` is 0.
- R2: `out_valid` equals the value `in_valid` had at the previous rising clock edge. The latency is exactly one cycle.
- R3: Slot k occupies bits [21k+20:21k] for k = 0, 1, 2, and slot 0 is the least significant. When exactly one slot equals the target, `out_result` is that slot's index k.
- R4: When several slots equal the target, `out_result` is the lowest matching index.
- R5: When no slot equals the target, `out_result` is all ones (-1 over 64 bits).
- R6: Bit 63 of `in_word` has no effect on the result.
- R7: A target of 0 finds the first zero slot, which is the terminator, under the same rules as any other code.
- R8: When `in_valid` is low, `out_result` keeps its previous value.
- R9: Whenever `out_valid` is high, `out_result` is 0, 1, 2 or -1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe for this cycle |
| in_word | input | 64 | Word holding three packed 21-bit codes |
| in_char | input | 21 | Target code to find |
| out_valid | output | 1 | Result is valid, one cycle after the request |
| out_result | output | 64 | Slot index 0..2, or -1 when no slot matches |

## Verification
The directed cases place the target in each single slot on its own. This separates the three field boundaries, so a shifted or mis-sized slice shows up as a wrong index. Words with two or three matching slots separate lowest-index priority from highest-index priority. Words with no match check the all-ones result. Pairs of words that differ only in bit 63 show whether the spare bit leaks into slot 2. A terminator case with code zero checks that zero is not treated specially. A cycle with `in_valid` low checks that the result holds. Random words then plant the target in a random set of slots among random codes. This mixes single, multiple and absent matches.

// File: rtl/ch21_pkg.sv
`timescale 1ns/1ps
package ch21_pkg;
  // Geometry of a packed word
  localparam int WORD_BITS  = 64;
  localparam int CODE_BITS  = 21;
  localparam int SLOT_COUNT = WORD_BITS / CODE_BITS;
  localparam int RESULT_BITS = 64;
endpackage

// File: rtl/ch21_slot_match.sv
`timescale 1ns/1ps
module ch21_slot_match #(
  parameter int WORD_W = ch21_pkg::WORD_BITS,
  parameter int CHAR_W = ch21_pkg::CODE_BITS,
  localparam int SLOTS = WORD_W / CHAR_W
) (
  input  logic [WORD_W-1:0] word,
  input  logic [CHAR_W-1:0] code,
  output logic [SLOTS-1:0]  hits
);
  // Field k sits at bits [k*CHAR_W +: CHAR_W]; spare top bits fall outside every field
  function automatic logic [CHAR_W-1:0] slot_field(input logic [WORD_W-1:0] w, input int k);
    return CHAR_W'(w >> (k * CHAR_W));
  endfunction

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    assign hits[k] = (slot_field(word, k) == code);
  end
endmodule

// File: rtl/ch21_first_hit.sv
`timescale 1ns/1ps
module ch21_first_hit #(
  parameter int SLOTS = ch21_pkg::SLOT_COUNT,
  localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic [SLOTS-1:0] hits,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  // Scan from the top down so the lowest set bit is written last and wins
  function automatic logic [IDX_W-1:0] lowest_set(input logic [SLOTS-1:0] h);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int k = SLOTS - 1; k >= 0; k--) begin
      if (h[k]) r = IDX_W'(k);
    end
    return r;
  endfunction

  assign idx = lowest_set(hits);
  assign any = |hits;
endmodule

// File: rtl/ch21_result_reg.sv
`timescale 1ns/1ps
module ch21_result_reg #(
  parameter int RES_W = ch21_pkg::RESULT_BITS,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             found,
  input  logic [IDX_W-1:0] idx,
  output logic             valid_q,
  output logic [RES_W-1:0] result_q
);
  // A miss encodes as -1, a hit as the zero-extended slot index
  function automatic logic [RES_W-1:0] encode(input logic f, input logic [IDX_W-1:0] i);
    return f ? RES_W'(i) : '1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      result_q <= '0;
    end else begin
      valid_q <= load;
      if (load) result_q <= encode(found, idx);
    end
  end
endmodule

// File: rtl/ch21_search.sv
`timescale 1ns/1ps
module ch21_search #(
  parameter int WORD_W = ch21_pkg::WORD_BITS,
  parameter int CHAR_W = ch21_pkg::CODE_BITS,
  parameter int RES_W  = ch21_pkg::RESULT_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  input  logic [CHAR_W-1:0] in_char,
  output logic              out_valid,
  output logic [RES_W-1:0]  out_result
);
  localparam int SLOTS = WORD_W / CHAR_W;
  localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  // Internal events named for the checker
  logic [SLOTS-1:0] hit_vec;
  logic [IDX_W-1:0] hit_idx;
  logic             any_hit;

  ch21_slot_match #(.WORD_W(WORD_W), .CHAR_W(CHAR_W)) match_i (
    .word(in_word), .code(in_char), .hits(hit_vec)
  );

  ch21_first_hit #(.SLOTS(SLOTS)) pick_i (
    .hits(hit_vec), .idx(hit_idx), .any(any_hit)
  );

  ch21_result_reg #(.RES_W(RES_W), .IDX_W(IDX_W)) out_i (
    .clk(clk), .rst_n(rst_n), .load(in_valid), .found(any_hit), .idx(hit_idx),
    .valid_q(out_valid), .result_q(out_result)
  );
endmodule

// File: rtl/ch21_search_chk.sv
`timescale 1ns/1ps
module ch21_search_chk #(
  parameter int SLOTS = 3,
  parameter int IDX_W = 2,
  parameter int RES_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             out_valid,
  input logic [RES_W-1:0] out_result,
  input logic [SLOTS-1:0] hit_vec,
  input logic [IDX_W-1:0] hit_idx,
  input logic             any_hit
);
  assert_reset_R1: assert property (@(posedge clk) !rst_n |=> (!out_valid && out_result == '0));

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_hit_index_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && any_hit) |=> out_result == RES_W'($past(hit_idx)));

  assert_lowest_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && hit_vec[0]) |=> out_result == '0);

  assert_miss_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !any_hit) |=> out_result == '1);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_result));

  assert_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_result < RES_W'(SLOTS) || out_result == '1));
endmodule

bind ch21_search ch21_search_chk #(.SLOTS(SLOTS), .IDX_W(IDX_W), .RES_W(RES_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .out_result(out_result), .hit_vec(hit_vec), .hit_idx(hit_idx), .any_hit(any_hit)
);

// File: tb/ch21_search_tb.sv
`timescale 1ns/1ps
module ch21_search_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] in_word = '0;
  logic [20:0] in_char = '0;
  logic        out_valid;
  logic [63:0] out_result;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  ch21_search dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .in_char(in_char), .out_valid(out_valid), .out_result(out_result)
  );

  // Reference: walk the slots with a mask, lowest first
  function automatic longint ref_find(input logic [63:0] w, input logic [20:0] c);
    for (int k = 0; k < 3; k++) begin
      logic [63:0] m;
      m = (w & (64'h1F_FFFF << (21 * k))) >> (21 * k);
      if (m[20:0] == c) return longint'(k);
    end
    return -64'sd1;
  endfunction

  function automatic logic [63:0] pack3(input logic [20:0] a, input logic [20:0] b,
                                        input logic [20:0] c, input logic top);
    return {top, c, b, a};
  endfunction

  task automatic check(input string tag, input logic ok, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive one request, then sample one cycle later away from the edge
  task automatic search(input string tag, input logic [63:0] w, input logic [20:0] c);
    logic [63:0] exp;
    exp = 64'(ref_find(w, c));
    in_valid = 1'b1; in_word = w; in_char = c;
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " R2 valid"}, out_valid === 1'b1, {63'd0, out_valid}, 64'd1);
    check(tag, out_result === exp, out_result, exp);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [63:0] held;
    void'($urandom(32'd20201201));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 valid", out_valid === 1'b0, {63'd0, out_valid}, 64'd0);
    check("R1 result", out_result === 64'd0, out_result, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 single match in each slot
    search("R3 slot0", pack3(21'h00ABC, 21'h11111, 21'h02222, 1'b0), 21'h00ABC);
    search("R3 slot1", pack3(21'h00ABC, 21'h11111, 21'h02222, 1'b0), 21'h11111);
    search("R3 slot2", pack3(21'h00ABC, 21'h11111, 21'h1FFFF, 1'b0), 21'h1FFFF);
    search("R3 slot2 max", pack3(21'h1, 21'h2, 21'h1FFFFF, 1'b0), 21'h1FFFFF);
    // R4 multiple matches
    search("R4 slots1,2", pack3(21'h5, 21'h7, 21'h7, 1'b0), 21'h7);
    search("R4 all", pack3(21'h9, 21'h9, 21'h9, 1'b1), 21'h9);
    search("R4 slots0,2", pack3(21'h3, 21'h4, 21'h3, 1'b0), 21'h3);
    // R5 misses
    search("R5 none", pack3(21'h1, 21'h2, 21'h3, 1'b0), 21'h4);
    search("R5 ones word", 64'hFFFF_FFFF_FFFF_FFFF, 21'h1FFFFE);
    // R6 top bit ignored
    search("R6 top0 hit", pack3(21'h1, 21'h2, 21'h0F0F0, 1'b0), 21'h0F0F0);
    search("R6 top1 hit", pack3(21'h1, 21'h2, 21'h0F0F0, 1'b1), 21'h0F0F0);
    search("R6 top1 miss", pack3(21'h1, 21'h2, 21'h3, 1'b1), 21'h100003);
    // R7 terminator
    search("R7 term slot2", pack3(21'h41, 21'h42, 21'h0, 1'b0), 21'h0);
    search("R7 term slot1", pack3(21'h41, 21'h0, 21'h0, 1'b1), 21'h0);
    search("R7 no term", pack3(21'h41, 21'h42, 21'h43, 1'b0), 21'h0);

    // R8 hold while idle
    search("R8 setup", pack3(21'h1, 21'h22, 21'h3, 1'b0), 21'h22);
    held = out_result;
    in_valid = 1'b0; in_word = pack3(21'h5, 21'h6, 21'h7, 1'b0); in_char = 21'h5;
    @(negedge clk);
    check("R8 hold", out_result === held, out_result, held);
    check("R2 idle valid", out_valid === 1'b0, {63'd0, out_valid}, 64'd0);

    // Random words with the target planted in a random set of slots
    for (int n = 0; n < 400; n++) begin
      logic [20:0] t;
      logic [20:0] s [3];
      logic [2:0]  plant;
      t = 21'($urandom);
      plant = 3'($urandom);
      for (int k = 0; k < 3; k++) s[k] = plant[k] ? t : 21'($urandom);
      search("R9 R3 R4 R5 random", pack3(s[0], s[1], s[2], 1'($urandom)), t);
      check("R9 range", out_result < 64'd3 || out_result === '1, out_result, 64'd2);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule